// File: doc/BRIEF.md
# Interrupt Merge and GPIO Output Register File

This block is a small register file reached over a byte-wide register bus. It has two jobs. First, it collects eight level-sensitive interrupt lines from neighbouring sub-functions into a status byte. It gates that byte with a mask byte and drives a single interrupt request upward. Second, it holds 24 bits of general-purpose output data and 24 bits of output enable, arranged as three byte lanes.

A pin's effective level is its data bit ANDed with its enable bit. When a write changes the effective level of any pin, the block reports it for one cycle on a change vector. A parallel vector carries the new levels, so a consumer downstream can follow pin transitions without polling.

The sub-interrupt inputs have fixed slots: bit 0 flash controller, bit 1 card controller, bit 2 USB host, bit 3 serial port, bit 4 display controller, and bits 5 to 7 spare. A routing byte is kept as plain read/write storage. Reads are combinational while the read strobe is high. Writes take effect at the clock edge where the write strobe is high. Every byte address reads or writes only its own byte.

Top module: `irq_gpio_regs`

## Requirements
- R1: After synchronous active-low reset, the following all read 0: status, mask, routing, every data lane and every enable lane. `irq_out` is 0, and no change event appears in the cycle after reset is released.
- R2: A status bit takes the level of its sub-interrupt input one clock after the input changes. This is set when the input rises and cleared when it falls. If a software write and an input change land in the same cycle, the input change wins for that bit.
- R3: `irq_out` is high exactly when status AND mask is nonzero. It follows a status or mask change in the same cycle that register updates.
- R4: Status (offset 0x50), mask (0x52) and routing (0x54) are each read/write bytes. A write to 0x50 loads status directly.
- R5: A read of offset 0x08 returns 0x03. A read of offset 0x09 returns 0x00.
- R6: Output data lanes sit at 0x78, 0x79 and 0x7A, and enable lanes at 0x7C, 0x7D and 0x7E. Lane n holds bits 8n+7 to 8n. A lane write changes only those eight bits.
- R7: In the cycle after a data or enable write, `gpio_chg` has a 1 for every bit whose effective level (data AND enable) changed. `gpio_lvl` carries the new effective levels. All changed bits are reported together, and the pulse lasts one cycle.
- R8: A write that leaves every effective level unchanged produces no change event. An example is new data on a lane whose enable bits are 0.
- R9: A read of any unmapped offset returns 0. A write to an unmapped offset changes no register, the interrupt output or any GPIO output.
- R10: `rd_data` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| sub_irq | input | 8 | Level interrupt lines from sub-functions |
| irq_out | output | 1 | Merged interrupt request |
| gpio_data | output | 24 | Output data register contents |
| gpio_oe | output | 24 | Output enable register contents |
| gpio_chg | output | 24 | One-cycle change flags per pin |
| gpio_lvl | output | 24 | Effective level per pin (data AND enable) |

## Verification
A wrong previous-level register shows at the ports as a change pulse that never ends, or as a pulse on a bit that did not move. It is visible in the cycle right after the offending write, and a check of `gpio_chg` there catches it. A stale input-sample register in the interrupt merge shows as a status bit that lags or ignores a sub-interrupt edge. It appears one clock after the input moves, both on a status read and on `irq_out` when the bit is unmasked. A decode slip, such as a lane written at the wrong address, shows at once when the neighbouring lanes and unmapped offsets are read back.

// File: rtl/irq_gpio_pkg.sv
// Package: register offsets and widths shared by the interrupt merge and
// GPIO output register file. Offsets are 8-bit byte addresses.
package irq_gpio_pkg;
    localparam int unsigned BUS_W = 8;
    localparam logic [BUS_W-1:0] OFS_REV_LO  = 8'h08;
    localparam logic [BUS_W-1:0] OFS_REV_HI  = 8'h09;
    localparam logic [BUS_W-1:0] OFS_STATUS  = 8'h50;
    localparam logic [BUS_W-1:0] OFS_MASK    = 8'h52;
    localparam logic [BUS_W-1:0] OFS_ROUTE   = 8'h54;
    localparam logic [BUS_W-1:0] OFS_DATA0   = 8'h78;
    localparam logic [BUS_W-1:0] OFS_OE0     = 8'h7C;
    localparam int unsigned MAX_LANES = 4;   // data and enable windows are 4 bytes apart

    typedef struct packed {
        logic wr_status;
        logic wr_mask;
        logic wr_route;
    } irq_wr_t;
endpackage

// File: rtl/irq_merge.sv
// Module: irq_merge
// Purpose: keeps the interrupt status, mask and routing bytes. Each status
// bit follows its sub-interrupt line one clock after the line moves. A
// software write loads status, but an input change in the same cycle wins
// for that bit. The request output is the OR of status AND mask.
// Assumes: N_SRC <= BUS_W; inputs are synchronous to clk.
module irq_merge
    import irq_gpio_pkg::*;
#(
    parameter int unsigned N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_in,
    input  irq_wr_t          wr,
    input  logic [BUS_W-1:0] wdata,
    output logic [N_SRC-1:0] status,
    output logic [N_SRC-1:0] mask,
    output logic [BUS_W-1:0] route,
    output logic             irq_req
);
    logic [N_SRC-1:0] src_q;
    logic [N_SRC-1:0] status_nxt;

    // Next status: software load first, then input transitions override.
    always_comb begin
        status_nxt = wr.wr_status ? wdata[N_SRC-1:0] : status;
        for (int i = 0; i < N_SRC; i++) begin
            if (src_in[i] != src_q[i]) status_nxt[i] = src_in[i];
        end
    end

    // Register input sample, status, mask and routing byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            status <= '0;
            mask   <= '0;
            route  <= '0;
        end else begin
            src_q  <= src_in;
            status <= status_nxt;
            if (wr.wr_mask)  mask  <= wdata[N_SRC-1:0];
            if (wr.wr_route) route <= wdata;
        end
    end

    // Merged request.
    assign irq_req = |(status & mask);

    // R2: a moved input line is reflected in status on the next edge.
    a_r2_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (src_in != src_q) |=>
            ((status & $past(src_in ^ src_q)) == ($past(src_in) & $past(src_in ^ src_q))));

    // R3: with an all-zero mask there is never a request.
    a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_req);

    // R1: reset leaves status and mask clear.
    a_r1_irq_reset: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && mask == '0));
endmodule

// File: rtl/gpio_out_bank.sv
// Module: gpio_out_bank
// Purpose: holds the GPIO output data and enable registers in byte lanes.
// It tracks the previous effective level (data AND enable) and flags every
// pin whose effective level differs from it for one cycle.
// Assumes: at most one lane write per cycle; write strobes are one-hot or 0.
module gpio_out_bank
    import irq_gpio_pkg::*;
#(
    parameter int unsigned LANES  = 3,
    localparam int unsigned PINS  = LANES * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] wr_data_lane,
    input  logic [LANES-1:0] wr_oe_lane,
    input  logic [BUS_W-1:0] wdata,
    output logic [PINS-1:0]  data_q,
    output logic [PINS-1:0]  oe_q,
    output logic [PINS-1:0]  chg_valid,
    output logic [PINS-1:0]  chg_level
);
    logic [PINS-1:0] prev_q;
    logic [PINS-1:0] eff;

    // One register slice per byte lane for data and enable.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Lane l storage update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[l*BUS_W +: BUS_W] <= '0;
                oe_q[l*BUS_W +: BUS_W]   <= '0;
            end else begin
                if (wr_data_lane[l]) data_q[l*BUS_W +: BUS_W] <= wdata;
                if (wr_oe_lane[l])   oe_q[l*BUS_W +: BUS_W]   <= wdata;
            end
        end
    end

    // Effective driven level.
    assign eff = data_q & oe_q;

    // Previous effective level catches up one cycle after each change.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= eff;
    end

    assign chg_valid = eff ^ prev_q;
    assign chg_level = eff;

    // R7: without a lane write in the previous cycle, no change is flagged.
    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        !(|{wr_data_lane, wr_oe_lane}) |=> (chg_valid == '0));

    // R6: a single lane write never moves the registers of other lanes.
    a_r6_lane_isolation: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_lane == '0) |=> $stable(data_q));

    // R1: reset produces no change event.
    a_r1_gpio_reset: assert property (@(posedge clk)
        !rst_n |=> (chg_valid == '0 && oe_q == '0));
endmodule

// File: rtl/irq_gpio_regs.sv
// Module: irq_gpio_regs (top)
// Purpose: decodes byte accesses onto the interrupt merge and GPIO output
// bank. It returns revision bytes and zero for unmapped offsets.
// Assumes: single-byte accesses; rd_en and wr_en are never both high.
module irq_gpio_regs
    import irq_gpio_pkg::*;
#(
    parameter int unsigned N_SRC      = 8,
    parameter int unsigned GPIO_LANES = 3,
    parameter logic [7:0]  REV_ID     = 8'h03,
    localparam int unsigned PINS      = GPIO_LANES * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             rd_en,
    input  logic             wr_en,
    output logic [7:0]       rd_data,
    input  logic [N_SRC-1:0] sub_irq,
    output logic             irq_out,
    output logic [PINS-1:0]  gpio_data,
    output logic [PINS-1:0]  gpio_oe,
    output logic [PINS-1:0]  gpio_chg,
    output logic [PINS-1:0]  gpio_lvl
);
    irq_wr_t               irq_wr;
    logic [N_SRC-1:0]      st_q;
    logic [N_SRC-1:0]      mk_q;
    logic [BUS_W-1:0]      rt_q;
    logic [GPIO_LANES-1:0] hit_data;
    logic [GPIO_LANES-1:0] hit_oe;
    logic                  hit;
    logic [BUS_W-1:0]      rd_mux;

    // Per-lane address matches.
    for (genvar l = 0; l < GPIO_LANES; l++) begin : g_dec
        assign hit_data[l] = (addr == OFS_DATA0 + 8'(l));
        assign hit_oe[l]   = (addr == OFS_OE0 + 8'(l));
    end

    // Write strobes for the interrupt registers.
    always_comb begin
        irq_wr.wr_status = wr_en && (addr == OFS_STATUS);
        irq_wr.wr_mask   = wr_en && (addr == OFS_MASK);
        irq_wr.wr_route  = wr_en && (addr == OFS_ROUTE);
    end

    irq_merge #(.N_SRC(N_SRC)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (sub_irq),
        .wr      (irq_wr),
        .wdata   (wdata),
        .status  (st_q),
        .mask    (mk_q),
        .route   (rt_q),
        .irq_req (irq_out)
    );

    gpio_out_bank #(.LANES(GPIO_LANES)) u_gpio (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_data_lane (hit_data & {GPIO_LANES{wr_en}}),
        .wr_oe_lane   (hit_oe & {GPIO_LANES{wr_en}}),
        .wdata        (wdata),
        .data_q       (gpio_data),
        .oe_q         (gpio_oe),
        .chg_valid    (gpio_chg),
        .chg_level    (gpio_lvl)
    );

    // Read multiplexer with hit flag; unmapped offsets give zero.
    always_comb begin
        rd_mux = '0;
        hit    = 1'b1;
        unique case (addr)
            OFS_REV_LO: rd_mux = REV_ID;
            OFS_REV_HI: rd_mux = '0;
            OFS_STATUS: rd_mux = BUS_W'(st_q);
            OFS_MASK:   rd_mux = BUS_W'(mk_q);
            OFS_ROUTE:  rd_mux = rt_q;
            default:    hit    = 1'b0;
        endcase
        for (int l = 0; l < GPIO_LANES; l++) begin
            if (hit_data[l]) begin
                rd_mux = gpio_data[l*BUS_W +: BUS_W];
                hit    = 1'b1;
            end
            if (hit_oe[l]) begin
                rd_mux = gpio_oe[l*BUS_W +: BUS_W];
                hit    = 1'b1;
            end
        end
    end

    // Drive read data only while the read strobe is high.
    assign rd_data = rd_en ? rd_mux : '0;

    // R9: unmapped reads return zero.
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |-> (rd_data == '0));

    // R10: idle read bus is zero.
    a_r10_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));

    // Lane windows must not overlap.
    initial begin
        a_lanes_fit: assert (GPIO_LANES <= MAX_LANES && N_SRC <= BUS_W);
    end
endmodule

// File: tb/test_irq_gpio_regs.sv
module test_irq_gpio_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  rd_data;
    logic [7:0]  sub_irq = '0;
    logic        irq_out;
    logic [23:0] gpio_data, gpio_oe, gpio_chg, gpio_lvl;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_gpio_regs i_irq_gpio_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .wr_en(wr_en), .rd_data(rd_data),
        .sub_irq(sub_irq), .irq_out(irq_out),
        .gpio_data(gpio_data), .gpio_oe(gpio_oe),
        .gpio_chg(gpio_chg), .gpio_lvl(gpio_lvl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write one byte; returns at the negedge after the capturing edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(tag, {24'd0, d}, {24'd0, exp});
    endtask

    task automatic t_reset;
        chk("R1 irq_out", {31'd0, irq_out}, 32'd0);
        chk("R1 chg", {8'd0, gpio_chg}, 32'd0);
        rd_chk("R1 status", 8'h50, 8'h00);
        rd_chk("R1 mask", 8'h52, 8'h00);
        rd_chk("R1 route", 8'h54, 8'h00);
        for (int l = 0; l < 3; l++) begin
            rd_chk("R1 data lane", 8'h78 + 8'(l), 8'h00);
            rd_chk("R1 oe lane", 8'h7C + 8'(l), 8'h00);
        end
        chk("R10 idle rd_data", {24'd0, rd_data}, 32'd0);
    endtask

    task automatic t_revision;
        rd_chk("R5 rev lo", 8'h08, 8'h03);
        rd_chk("R5 rev hi", 8'h09, 8'h00);
    endtask

    task automatic t_status_follow;
        @(negedge clk); sub_irq = 8'h05;
        @(negedge clk);
        rd_chk("R2 status set", 8'h50, 8'h05);
        chk("R3 masked off", {31'd0, irq_out}, 32'd0);
        wr(8'h52, 8'h04);
        chk("R3 unmasked", {31'd0, irq_out}, 32'd1);
        sub_irq = 8'h01;
        @(negedge clk);
        chk("R3 source dropped", {31'd0, irq_out}, 32'd0);
        rd_chk("R2 status clear", 8'h50, 8'h01);
        // Same-cycle write and input change: input wins on its bit.
        @(negedge clk);
        addr = 8'h50; wdata = 8'h00; wr_en = 1'b1; sub_irq = 8'h03;
        @(negedge clk); wr_en = 1'b0;
        rd_chk("R2 input beats write", 8'h50, 8'h02);
        sub_irq = 8'h00;
        @(negedge clk);
    endtask

    task automatic t_sw_regs;
        wr(8'h50, 8'h00);
        wr(8'h52, 8'h80);
        chk("R3 no status", {31'd0, irq_out}, 32'd0);
        wr(8'h50, 8'h80);
        chk("R4 sw status irq", {31'd0, irq_out}, 32'd1);
        rd_chk("R4 status rb", 8'h50, 8'h80);
        wr(8'h54, 8'hA5);
        rd_chk("R4 route rb", 8'h54, 8'hA5);
        wr(8'h50, 8'h00);
        chk("R4 status cleared", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_gpio;
        wr(8'h7D, 8'hFF);
        chk("R8 enable only", {8'd0, gpio_chg}, 32'd0);
        wr(8'h79, 8'h3C);
        chk("R7 chg", {8'd0, gpio_chg}, 32'h003C00);
        chk("R7 lvl", {8'd0, gpio_lvl}, 32'h003C00);
        @(negedge clk);
        chk("R7 pulse ends", {8'd0, gpio_chg}, 32'd0);
        rd_chk("R6 lane1", 8'h79, 8'h3C);
        rd_chk("R6 lane0", 8'h78, 8'h00);
        wr(8'h7D, 8'h0F);
        chk("R7 disable chg", {8'd0, gpio_chg}, 32'h003000);
        chk("R7 disable lvl", {8'd0, gpio_lvl}, 32'h000C00);
        wr(8'h7A, 8'hFF);
        chk("R8 data no oe", {8'd0, gpio_chg}, 32'd0);
        chk("R6 data out", {8'd0, gpio_data}, 32'hFF3C00);
        wr(8'h7C, 8'h81);
        wr(8'h78, 8'h81);
        chk("R7 lane0 chg", {8'd0, gpio_chg}, 32'h000081);
        wr(8'h7E, 8'hFF);
        chk("R7 lane2 chg", {8'd0, gpio_chg}, 32'hFF0000);
        chk("R6 oe out", {8'd0, gpio_oe}, 32'hFF0F81);
    endtask

    task automatic t_unmapped;
        wr(8'h51, 8'hFF);
        wr(8'h7B, 8'hFF);
        wr(8'h7F, 8'hFF);
        chk("R9 no chg", {8'd0, gpio_chg}, 32'd0);
        chk("R9 data kept", {8'd0, gpio_data}, 32'hFF3C81);
        chk("R9 irq kept", {31'd0, irq_out}, 32'd0);
        rd_chk("R9 read 51", 8'h51, 8'h00);
        rd_chk("R9 read 7B", 8'h7B, 8'h00);
        rd_chk("R9 read F0", 8'hF0, 8'h00);
        rd_chk("R9 mask kept", 8'h52, 8'h80);
        rd_chk("R9 status kept", 8'h50, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_revision();
        t_status_follow();
        t_sw_regs();
        t_gpio();
        t_unmapped();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule